// File: doc/BRIEF.md
# Raster Scan-Out Engine for a 640x480 True-Color Panel

This block reads a true-color picture from system memory and turns it into a pixel stream for a TFT panel or a VGA encoder. It counts through a standard 640x480 60 Hz raster, issues one memory read per visible pixel on a simple request/valid port, unpacks each returned 32-bit word into 8-bit red, green and blue channels, and drives them together with active-low horizontal and vertical sync and a data-enable strobe.

Software programs two 32-bit registers: a picture base address, of which only the upper 11 bits are kept (so the picture starts on a 2 MiB boundary), and a control word holding a display-on bit and a half-turn bit. Each picture line takes a fixed stride of 1024 words, of which only the leading 640 are fetched. With the half-turn bit set the whole scan runs backwards, from the last word of the last line to the first word of the first line. Both registers are copied into working copies only when vertical blanking begins, so a write made during a frame never changes that frame.

All raster sizes, the line stride, the memory read latency and the base-address width are parameters; the defaults give the 640x480 mode.

Top module: `fbs_scanout`

## Requirements
- R1: Register word 0 holds the base address and reads back only its upper BASE_BITS bits (bits 31:21 by default), lower bits read as zero; register word 1 reads back only control bits 1:0, upper bits zero. Writes take effect on the next clock; readback is combinational.
- R2: After reset both registers read zero, no memory request is issued, data-enable is low, the color outputs are zero and both syncs are high.
- R3: When the working copy of control bit 0 (display on) is zero, no memory request is issued and data-enable stays low.
- R4: With control bit 1 clear, requests follow raster order; the byte address of line r, column c is {base[31:21], (r*STRIDE + c)*4}, so words from column H_ACT up to STRIDE-1 of each line are never requested.
- R5: With control bit 1 set, the first request of a frame targets line V_ACT-1, column H_ACT-1, and the scan runs backwards through columns and lines with the same STRIDE.
- R6: A returned word is shown exactly RD_LAT+1 cycles after its request: red from bits 23:16, green from 15:8, blue from 7:0; bits 31:24 have no effect.
- R7: Whenever data-enable is low, red, green and blue are zero.
- R8: Each line lasts H_ACT+H_FP+H_SYNC+H_BP cycles and horizontal sync is low for H_SYNC consecutive cycles per line.
- R9: Each frame lasts V_ACT+V_FP+V_SYNC+V_BP lines and vertical sync is low for V_SYNC whole lines.
- R10: Register values are copied into the scan only at the first cycle of vertical blanking; a write during an active frame leaves the rest of that frame unchanged.
- R11: Writing 0 to the control word blanks the display from the next frame on; writing bit 0 back restores the picture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 1 | Register word select: 0 base, 1 control |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Readback of the selected register |
| memReq | output | 1 | Read request for one pixel word |
| memAddr | output | 32 | Byte address of the requested word |
| memRdValid | input | 1 | Returned word valid, RD_LAT cycles after the request |
| memRdData | input | 32 | Returned pixel word |
| pixRed | output | 8 | Red channel |
| pixGreen | output | 8 | Green channel |
| pixBlue | output | 8 | Blue channel |
| hSync | output | 1 | Horizontal sync, active low |
| vSync | output | 1 | Vertical sync, active low |
| dataEn | output | 1 | High while a visible pixel is driven |

## Verification
Register readback is due in the same cycle the select changes, and a write shows in readback from the next cycle, but it reaches the scan only at the next start of vertical blanking; the bench keeps its own copies of both the written and the working values and swaps them at that exact raster position. The request and its address are due in the very cycle the raster counters reach a visible position, so the bench runs its own raster counters from reset and compares memReq and memAddr every cycle. Each pixel is due RD_LAT+1 cycles after its request; the bench queues the expected color with the request cycle and, when data-enable appears, checks both the color and that the distance is exactly RD_LAT+1.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  // control word bit positions (software visible)
  localparam int CTL_ON  = 0;
  localparam int CTL_ROT = 1;

  // strobes from the raster control to the datapath
  typedef struct packed {
    logic fetch;    // visible position with display on
    logic lastCol;  // counter sits on the last visible column
    logic arm;      // start of the final blanking line: preset address
    logic hsRaw;    // undelayed horizontal sync, active low
    logic vsRaw;    // undelayed vertical sync, active low
  } scanStrobe_t;

  // bits carried down the latency pipe
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } pipeBits_t;

endpackage

// File: rtl/fbs_ctrl.sv
module fbs_ctrl
  import fbs_pkg::*;
#(
  parameter int H_ACT     = 640,
  parameter int H_FP      = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BP      = 48,
  parameter int V_ACT     = 480,
  parameter int V_FP      = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BP      = 33,
  parameter int ADDR_W    = 32,
  parameter int BASE_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regAddr,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regWrData,
  output logic [ADDR_W-1:0]    regRdData,
  output scanStrobe_t          stb,
  output logic [BASE_BITS-1:0] shBase,
  output logic                 shRot
);

  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HCW   = $clog2(H_TOT);
  localparam int VCW   = $clog2(V_TOT);
  localparam int LOW_W = ADDR_W - BASE_BITS;

  localparam logic [HCW-1:0] H_ACT_C  = HCW'(H_ACT);
  localparam logic [HCW-1:0] H_LASTC  = HCW'(H_ACT - 1);
  localparam logic [HCW-1:0] H_LAST   = HCW'(H_TOT - 1);
  localparam logic [HCW-1:0] HS_BEG   = HCW'(H_ACT + H_FP);
  localparam logic [HCW-1:0] HS_END   = HCW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VCW-1:0] V_ACT_C  = VCW'(V_ACT);
  localparam logic [VCW-1:0] V_LAST   = VCW'(V_TOT - 1);
  localparam logic [VCW-1:0] VS_BEG   = VCW'(V_ACT + V_FP);
  localparam logic [VCW-1:0] VS_END   = VCW'(V_ACT + V_FP + V_SYNC);

  logic [BASE_BITS-1:0] baseReg;
  logic [1:0]           ctrlReg;
  logic                 shOn;
  logic [HCW-1:0]       hCnt;
  logic [VCW-1:0]       vCnt;
  logic                 loadPt;
  logic [ADDR_W-1:0]    unusedWrBits;

  assign unusedWrBits = regWrData;
  assign loadPt = (hCnt == '0) && (vCnt == V_ACT_C);

  // register file and the working copies taken at blanking start
  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg <= '0;
      ctrlReg <= '0;
      shBase  <= '0;
      shOn    <= 1'b0;
      shRot   <= 1'b0;
    end else begin
      if (loadPt) begin
        shBase <= baseReg;
        shOn   <= ctrlReg[CTL_ON];
        shRot  <= ctrlReg[CTL_ROT];
      end
      if (regWrEn) begin
        if (!regAddr) baseReg <= regWrData[ADDR_W-1 -: BASE_BITS];
        else          ctrlReg <= regWrData[1:0];
      end
    end
  end

  always_comb begin
    if (regAddr) regRdData = {{(ADDR_W-2){1'b0}}, ctrlReg};
    else         regRdData = {baseReg, {LOW_W{1'b0}}};
  end

  // raster counters
  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hCnt == H_LAST) begin
      hCnt <= '0;
      vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    stb.fetch   = (hCnt < H_ACT_C) && (vCnt < V_ACT_C) && shOn;
    stb.lastCol = (hCnt == H_LASTC);
    stb.arm     = (hCnt == '0) && (vCnt == V_LAST);
    stb.hsRaw   = !((hCnt >= HS_BEG) && (hCnt < HS_END));
    stb.vsRaw   = !((vCnt >= VS_BEG) && (vCnt < VS_END));
  end

endmodule

// File: rtl/fbs_datapath.sv
module fbs_datapath
  import fbs_pkg::*;
#(
  parameter int H_ACT     = 640,
  parameter int V_ACT     = 480,
  parameter int STRIDE    = 1024,
  parameter int RD_LAT    = 2,
  parameter int ADDR_W    = 32,
  parameter int BASE_BITS = 11,
  parameter int CH_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  scanStrobe_t          stb,
  input  logic [BASE_BITS-1:0] shBase,
  input  logic                 shRot,
  output logic                 memReq,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic                 memRdValid,
  input  logic [4*CH_W-1:0]    memRdData,
  output logic [CH_W-1:0]      pixRed,
  output logic [CH_W-1:0]      pixGreen,
  output logic [CH_W-1:0]      pixBlue,
  output logic                 hSync,
  output logic                 vSync,
  output logic                 dataEn
);

  localparam int LOW_W = ADDR_W - BASE_BITS;
  localparam int OFF_W = LOW_W - 2;
  localparam logic [OFF_W-1:0] ROW_JUMP = OFF_W'(STRIDE - H_ACT + 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'((V_ACT - 1) * STRIDE + H_ACT - 1);
  localparam pipeBits_t IDLE = '{de: 1'b0, hs: 1'b1, vs: 1'b1};

  logic [OFF_W-1:0] curOff;
  pipeBits_t        pipe [RD_LAT];
  pipeBits_t        tail;
  logic [CH_W-1:0]  unusedPad;

  assign unusedPad = memRdData[4*CH_W-1 -: CH_W];

  // word offset walker: forward or backward with the fixed line stride
  always_ff @(posedge clk) begin
    if (rst) begin
      curOff <= '0;
    end else if (stb.arm) begin
      curOff <= shRot ? LAST_OFF : '0;
    end else if (stb.fetch) begin
      if (shRot) curOff <= curOff - (stb.lastCol ? ROW_JUMP : OFF_W'(1));
      else       curOff <= curOff + (stb.lastCol ? ROW_JUMP : OFF_W'(1));
    end
  end

  assign memReq  = stb.fetch;
  assign memAddr = {shBase, curOff, 2'b00};

  // timing bits wait for the memory latency
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RD_LAT; i++) pipe[i] <= IDLE;
    end else begin
      for (int i = RD_LAT - 1; i > 0; i--) pipe[i] <= pipe[i-1];
      pipe[0] <= '{de: stb.fetch, hs: stb.hsRaw, vs: stb.vsRaw};
    end
  end

  assign tail = pipe[RD_LAT-1];

  // output stage: unpack the three channels
  always_ff @(posedge clk) begin
    if (rst) begin
      dataEn   <= 1'b0;
      hSync    <= 1'b1;
      vSync    <= 1'b1;
      pixRed   <= '0;
      pixGreen <= '0;
      pixBlue  <= '0;
    end else begin
      dataEn <= tail.de;
      hSync  <= tail.hs;
      vSync  <= tail.vs;
      if (tail.de && memRdValid) begin
        pixRed   <= memRdData[3*CH_W-1 -: CH_W];
        pixGreen <= memRdData[2*CH_W-1 -: CH_W];
        pixBlue  <= memRdData[CH_W-1:0];
      end else begin
        pixRed   <= '0;
        pixGreen <= '0;
        pixBlue  <= '0;
      end
    end
  end

endmodule

// File: rtl/fbs_scanout.sv
module fbs_scanout
  import fbs_pkg::*;
#(
  parameter int H_ACT     = 640,
  parameter int H_FP      = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BP      = 48,
  parameter int V_ACT     = 480,
  parameter int V_FP      = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BP      = 33,
  parameter int STRIDE    = 1024,
  parameter int RD_LAT    = 2,
  parameter int ADDR_W    = 32,
  parameter int BASE_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regAddr,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [31:0]       memRdData,
  output logic [7:0]        pixRed,
  output logic [7:0]        pixGreen,
  output logic [7:0]        pixBlue,
  output logic              hSync,
  output logic              vSync,
  output logic              dataEn
);

  scanStrobe_t          stb;
  logic [BASE_BITS-1:0] shBase;
  logic                 shRot;

  fbs_ctrl #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .ADDR_W(ADDR_W), .BASE_BITS(BASE_BITS)
  ) uCtrl (
    .clk(clk), .rst(rst),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData),
    .stb(stb), .shBase(shBase), .shRot(shRot)
  );

  fbs_datapath #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .STRIDE(STRIDE), .RD_LAT(RD_LAT),
    .ADDR_W(ADDR_W), .BASE_BITS(BASE_BITS), .CH_W(8)
  ) uPath (
    .clk(clk), .rst(rst),
    .stb(stb), .shBase(shBase), .shRot(shRot),
    .memReq(memReq), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn)
  );

endmodule

// File: rtl/fbs_scanout_chk.sv
module fbs_scanout_chk #(
  parameter int RD_LAT    = 2,
  parameter int H_SYNC    = 96,
  parameter int ADDR_W    = 32,
  parameter int BASE_BITS = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              memReq,
  input logic              dataEn,
  input logic [7:0]        pixRed,
  input logic [7:0]        pixGreen,
  input logic [7:0]        pixBlue,
  input logic              hSync,
  input logic              regAddr,
  input logic [ADDR_W-1:0] regRdData,
  input logic              shRot
);

  localparam int LOW_W = ADDR_W - BASE_BITS;

  int cyc;
  int hsLow;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc   <= 0;
      hsLow <= 0;
    end else begin
      if (cyc < RD_LAT + 2) cyc <= cyc + 1;
      hsLow <= hSync ? 0 : hsLow + 1;
    end
  end

  // R7: blank pixels carry no color
  a_r7_blank_black: assert property (@(posedge clk) disable iff (rst)
    !dataEn |-> ({pixRed, pixGreen, pixBlue} == 24'h0));

  // R6: data-enable trails the request by the read latency plus one
  a_r6_pixel_latency: assert property (@(posedge clk) disable iff (rst)
    (cyc > RD_LAT + 1) |-> (dataEn == $past(memReq, RD_LAT + 1)));

  // R1: control word reads back only its two bits
  a_r1_ctrl_clean: assert property (@(posedge clk) disable iff (rst)
    regAddr |-> (regRdData[ADDR_W-1:2] == '0));

  // R1: base reads back with the low address bits clear
  a_r1_base_aligned: assert property (@(posedge clk) disable iff (rst)
    !regAddr |-> (regRdData[LOW_W-1:0] == '0));

  // R8: sync pulse never longer than its width
  a_r8_hsync_width: assert property (@(posedge clk) disable iff (rst)
    hsLow <= H_SYNC);

  // R10: the orientation in use cannot change while pixels are fetched
  a_r10_frame_stable: assert property (@(posedge clk) disable iff (rst)
    memReq |=> $stable(shRot));

endmodule

bind fbs_scanout fbs_scanout_chk #(
  .RD_LAT(RD_LAT), .H_SYNC(H_SYNC), .ADDR_W(ADDR_W), .BASE_BITS(BASE_BITS)
) uChk (
  .clk(clk), .rst(rst), .memReq(memReq), .dataEn(dataEn),
  .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue),
  .hSync(hSync), .regAddr(regAddr), .regRdData(regRdData), .shRot(shRot)
);

// File: tb/sim_fbs_scanout.sv
module sim_fbs_scanout;

  localparam int CLK_PERIOD = 10;
  localparam int H_ACT = 8, H_FP = 2, H_SYNC = 3, H_BP = 2;
  localparam int V_ACT = 4, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int STRIDE = 16;
  localparam int RD_LAT = 2;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;

  logic        clk = 1'b0;
  logic        rst;
  logic        regAddr, regWrEn;
  logic [31:0] regWrData, regRdData;
  logic        memReq, memRdValid;
  logic [31:0] memAddr, memRdData;
  logic [7:0]  pixRed, pixGreen, pixBlue;
  logic        hSync, vSync, dataEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbs_scanout #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .STRIDE(STRIDE), .RD_LAT(RD_LAT), .ADDR_W(32), .BASE_BITS(11)
  ) u0 (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // pixel word stored at a byte address; top byte is junk that must be ignored
  function automatic logic [31:0] memWord(logic [31:0] a);
    return {8'hC3, a[9:2] ^ 8'h11, a[9:2] + 8'h40, a[28:21]};
  endfunction

  // memory model with fixed read latency
  logic        rqP [RD_LAT];
  logic [31:0] adP [RD_LAT];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RD_LAT; i++) begin rqP[i] <= 1'b0; adP[i] <= '0; end
    end else begin
      for (int i = RD_LAT - 1; i > 0; i--) begin rqP[i] <= rqP[i-1]; adP[i] <= adP[i-1]; end
      rqP[0] <= memReq;
      adP[0] <= memAddr;
    end
  end
  assign memRdValid = rqP[RD_LAT-1];
  assign memRdData  = rqP[RD_LAT-1] ? memWord(adP[RD_LAT-1]) : 32'h0;

  // scoreboard state
  logic [23:0] expQ[$];
  int          expCyc[$];
  int          hB = 0, vB = 0, cyc = 0;
  logic [10:0] regBase = '0, shBase = '0;
  logic [1:0]  regCtl = '0, shCtl = '0;
  bit          frameWrite = 0;
  string       phaseTag = "R3";
  int          pixCount = 0, reqCount = 0;

  // monitor: own raster model, compares every cycle at the falling edge
  initial begin : monitor
    bit prevHs = 1, prevVs = 1;
    int hsRun = 0, vsRun = 0, hsFall = -1, vsFall = -1;
    wait (rst === 1'b1);
    wait (rst === 1'b0);
    forever begin
      @(negedge clk);
      // displayed pixels
      if (dataEn) begin
        pixCount++;
        if (expQ.size() == 0) begin
          chk(0, phaseTag, "pixel with no request", {8'h0, pixRed, pixGreen, pixBlue}, 32'h0);
        end else begin
          logic [23:0] e;
          int pc;
          e  = expQ.pop_front();
          pc = expCyc.pop_front();
          chk({pixRed, pixGreen, pixBlue} == e, "R6", "pixel color", {8'h0, pixRed, pixGreen, pixBlue}, {8'h0, e});
          chk(cyc - pc == RD_LAT + 1, "R6", "pixel latency", cyc - pc, RD_LAT + 1);
        end
      end else begin
        chk({pixRed, pixGreen, pixBlue} == 24'h0, "R7", "color while blank", {8'h0, pixRed, pixGreen, pixBlue}, 32'h0);
      end
      // horizontal sync
      if (!hSync) hsRun++;
      else if (hsRun > 0) begin
        chk(hsRun == H_SYNC, "R8", "hsync width", hsRun, H_SYNC);
        hsRun = 0;
      end
      if (prevHs && !hSync) begin
        if (hsFall >= 0) chk(cyc - hsFall == H_TOT, "R8", "line period", cyc - hsFall, H_TOT);
        hsFall = cyc;
      end
      prevHs = hSync;
      // vertical sync
      if (!vSync) vsRun++;
      else if (vsRun > 0) begin
        chk(vsRun == V_SYNC * H_TOT, "R9", "vsync width", vsRun, V_SYNC * H_TOT);
        vsRun = 0;
      end
      if (prevVs && !vSync) begin
        if (vsFall >= 0) chk(cyc - vsFall == H_TOT * V_TOT, "R9", "frame period", cyc - vsFall, H_TOT * V_TOT);
        vsFall = cyc;
      end
      prevVs = vSync;
      // requests
      begin
        bit    vis, fe;
        string tag;
        vis = (hB < H_ACT) && (vB < V_ACT);
        fe  = vis && shCtl[0];
        if (!shCtl[0])      tag = phaseTag;
        else if (frameWrite) tag = "R10";
        else if (shCtl[1])  tag = "R5";
        else                tag = "R4";
        chk(memReq == fe, tag, "request strobe", memReq, fe);
        if (memReq) reqCount++;
        if (fe) begin
          int r, c, off;
          logic [31:0] ea;
          r   = shCtl[1] ? V_ACT - 1 - vB : vB;
          c   = shCtl[1] ? H_ACT - 1 - hB : hB;
          off = r * STRIDE + c;
          ea  = {shBase, 21'(off * 4)};
          chk(memAddr == ea, tag, "request address", memAddr, ea);
          expQ.push_back(memWord(ea)[23:0]);
          expCyc.push_back(cyc);
        end
      end
      // working copies load at blanking start, using values before this cycle's write
      if (hB == 0 && vB == V_ACT) begin
        shBase = regBase;
        shCtl  = regCtl;
        frameWrite = 0;
      end
      if (regWrEn) begin
        if (!regAddr) regBase = regWrData[31:21];
        else          regCtl  = regWrData[1:0];
        if (vB < V_ACT && shCtl[0]) frameWrite = 1;
      end
      // advance model raster
      cyc++;
      if (hB == H_TOT - 1) begin
        hB = 0;
        vB = (vB == V_TOT - 1) ? 0 : vB + 1;
      end else begin
        hB++;
      end
    end
  end

  task automatic wr(logic a, logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic a, logic [31:0] exp, string req);
    @(posedge clk); #1;
    regAddr = a;
    #1;
    chk(regRdData == exp, req, "register readback", regRdData, exp);
  endtask

  task automatic waitFrames(int n);
    repeat (n * H_TOT * V_TOT) @(posedge clk);
  endtask

  // driver
  initial begin : driver
    int p0;
    rst = 1'b1; regAddr = 1'b0; regWrEn = 1'b0; regWrData = '0;
    repeat (4) @(posedge clk);
    #1;
    chk(dataEn == 1'b0, "R2", "reset data-enable", dataEn, 0);
    chk({pixRed, pixGreen, pixBlue} == 24'h0, "R2", "reset color", {8'h0, pixRed, pixGreen, pixBlue}, 0);
    chk(hSync && vSync, "R2", "reset syncs", {hSync, vSync}, 2'b11);
    chk(memReq == 1'b0, "R2", "reset request", memReq, 0);
    chk(regRdData == 32'h0, "R2", "reset base", regRdData, 0);
    regAddr = 1'b1; #1;
    chk(regRdData == 32'h0, "R2", "reset control", regRdData, 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R1: readback keeps only the defined bits
    wr(0, 32'hFFFF_FFFF); rd(0, 32'hFFE0_0000, "R1");
    wr(1, 32'hFFFF_FFFC); rd(1, 32'h0, "R1");
    wr(1, 32'h2);         rd(1, 32'h2, "R1");
    wr(1, 32'h0);
    wr(0, 32'h1A3F_FFFC); rd(0, 32'h1A20_0000, "R1");

    // R3: display off, nothing fetched or shown
    waitFrames(2);
    chk(pixCount == 0, "R3", "pixels while off", pixCount, 0);
    chk(reqCount == 0, "R3", "requests while off", reqCount, 0);

    // R4/R6: forward scan
    wr(1, 32'h1);
    waitFrames(3);
    chk(pixCount > 0, "R4", "pixels shown after enable", pixCount, 1);

    // R10/R5: change orientation and base mid-frame
    do @(posedge clk); while (vB != 1);
    wr(1, 32'h3);
    wr(0, 32'h4420_0000);
    rd(1, 32'h3, "R1");
    waitFrames(3);

    // R11: blank then restore
    phaseTag = "R11";
    wr(1, 32'h0);
    waitFrames(1);
    p0 = pixCount;
    waitFrames(2);
    chk(pixCount == p0, "R11", "pixels while blanked", pixCount, p0);
    wr(1, 32'h1);
    waitFrames(2);
    chk(pixCount > p0, "R11", "pixels after restore", pixCount, p0 + 1);

    // drain and close
    wr(1, 32'h0);
    waitFrames(2);
    chk(expQ.size() == 0, "R6", "undelivered pixels", expQ.size(), 0);
    finishRun();
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    finishRun();
  end

endmodule